// File: doc/BRIEF.md
# Cooperative Job Scheduler

This block holds a small table of jobs and decides which one owns a shared execution engine. Switching is cooperative. The running job keeps the engine until it gives it up in one of four ways: it yields, it asks to be retried because a downstream queue was full, it waits on an event, or it finishes. When the engine is released, the scheduler picks the next ready job in round-robin order. The search starts at the slot after the job that ran most recently.

Jobs are created in one of two forms. An immediate job is ready at once. A deferred job is parked until a launch command names its id. A launch never preempts the running job; the launched job only competes at the next selection. A job that waits on an event parks with an event tag, which can stand for a DMA handle, a barrier, a completion count or queue space. A wake pulse carrying the same tag makes every job parked on that tag ready again. If the event has already completed, the waiting job simply keeps running.

The engine sees the selected job id and a valid flag. An error pulse marks commands that were ignored. A one-cycle pulse reports the moment every job in the table has finished.

Top module: `coop_job_sched`

## Requirements
- R1: While reset is asserted and just after it is released, run_valid, cmd_err and all_done are 0 and run_job_id is 0.
- R2: Create (cmd_op 1) stores the job id in the lowest free slot as ready. If no job is running, a ready job is selected and shows on run_valid/run_job_id one clock after the command edge.
- R3: Create-deferred (cmd_op 2) stores the job without making it selectable. Launch (cmd_op 3) with that id makes it ready without disturbing the running job.
- R4: Yield (cmd_op 4) returns the running job to ready and selects the first ready slot after the last-run slot, wrapping around. The yielding job is chosen again only when no other slot is ready.
- R5: Retry (cmd_op 5, downstream queue full) behaves exactly like yield.
- R6: Block (cmd_op 6) parks the running job on cmd_tag and selects another job. A wake_valid pulse makes every job parked on wake_tag ready. A wake with any other tag changes nothing.
- R7: Block with cmd_evt_done=1, or with wake_valid=1 and wake_tag equal to cmd_tag in the same cycle, keeps the same job running with no switch.
- R8: These commands raise cmd_err for one cycle and change no state: a launch of an id that is not deferred (second launch, unknown id), or yield/retry/block/end while run_valid=0.
- R9: End (cmd_op 7) marks the running job done, and it is never selected again. When every used slot is done, all_done pulses for exactly one cycle with run_valid=0.
- R10: When no job is ready at a selection, run_valid is 0 and run_job_id is 0. The next job to become ready is then selected without any command.
- R11: A create when all NUM_JOBS slots are used raises cmd_err and is ignored.
- R12: A create whose id already exists in the table is ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 create, 2 create-deferred, 3 launch, 4 yield, 5 retry, 6 block, 7 end |
| cmd_job_id | input | ID_W | Job id for create and launch |
| cmd_tag | input | TAG_W | Event tag for block |
| cmd_evt_done | input | 1 | Event of a block already complete |
| wake_valid | input | 1 | Event completion strobe |
| wake_tag | input | TAG_W | Tag of the completed event |
| run_valid | output | 1 | A job owns the engine |
| run_job_id | output | ID_W | Id of the owning job, 0 when idle |
| cmd_err | output | 1 | Previous command was illegal and ignored |
| all_done | output | 1 | One-cycle pulse when all used jobs have ended |

## Verification
A block command and an event completion can land in the same cycle. If the wake carries the tag the running job is about to wait on, the wait must collapse into "already complete": no park and no switch. The bench drives a block and a wake with matching tags on the same edge, expects the same id still running one cycle later, and checks separately that a wake with a different tag leaves parked jobs untouched. A bench-side model of the table predicts every selection through yield, retry, block, wake, launch and end sweeps.

// File: rtl/csched_pkg.sv
package csched_pkg;

  typedef enum logic [2:0] {
    ST_FREE  = 3'd0,
    ST_DEFER = 3'd1,
    ST_READY = 3'd2,
    ST_RUN   = 3'd3,
    ST_BLOCK = 3'd4,
    ST_DONE  = 3'd5
  } job_st_e;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_CREATE     = 3'd1,
    OP_CREATE_DEF = 3'd2,
    OP_LAUNCH     = 3'd3,
    OP_YIELD      = 3'd4,
    OP_RETRY      = 3'd5,
    OP_BLOCK      = 3'd6,
    OP_END        = 3'd7
  } sched_op_e;

endpackage

// File: rtl/csched_table.sv
module csched_table
  import csched_pkg::*;
#(
  parameter int N      = 8,
  parameter int ID_W   = 16,
  parameter int TAG_W  = 8,
  parameter int SLOT_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cre_en,
  input  logic                     cre_defer,
  input  logic [ID_W-1:0]          cre_id,
  input  logic                     lau_en,
  input  logic [ID_W-1:0]          lau_id,
  input  logic                     rel_en,
  input  logic [SLOT_W-1:0]        rel_slot,
  input  job_st_e                  rel_state,
  input  logic [TAG_W-1:0]         rel_tag,
  input  logic                     wake_en,
  input  logic [TAG_W-1:0]         wake_tag,
  input  logic                     gnt_en,
  input  logic [SLOT_W-1:0]        gnt_slot,
  output logic [N-1:0]             ready_mid,
  output logic [N-1:0][2:0]        st_vec,
  output logic [N-1:0][ID_W-1:0]   id_vec,
  output logic                     cre_err,
  output logic                     lau_err
);

  logic [N-1:0]      free_vec;
  logic [N-1:0]      defer_vec;
  logic [N-1:0]      cre_match;
  logic [N-1:0]      lau_match;
  logic [SLOT_W-1:0] free_slot;
  logic              cre_go;

  // lowest free slot wins
  always_comb begin
    free_slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    cre_go  = cre_en && !(|cre_match) && (|free_vec);
    cre_err = cre_en && !(|cre_match) && !(|free_vec);
    lau_err = lau_en && !(|(lau_match & defer_vec));
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    job_st_e           st_r;
    logic [ID_W-1:0]   id_r;
    logic [TAG_W-1:0]  tag_r;
    job_st_e           st_mid;
    job_st_e           st_nxt;
    logic              cre_hit, lau_hit, rel_hit, wak_hit, gnt_hit, st_en;

    assign free_vec[g]  = (st_r == ST_FREE);
    assign defer_vec[g] = (st_r == ST_DEFER);
    assign cre_match[g] = (st_r != ST_FREE) && (id_r == cre_id);
    assign lau_match[g] = (st_r != ST_FREE) && (id_r == lau_id);

    // command and wake effects: each applies to a distinct current state
    always_comb begin
      cre_hit = cre_go && (free_slot == SLOT_W'(g));
      lau_hit = lau_en && lau_match[g] && (st_r == ST_DEFER);
      rel_hit = rel_en && (rel_slot == SLOT_W'(g));
      wak_hit = wake_en && (st_r == ST_BLOCK) && (tag_r == wake_tag);
      st_mid  = st_r;
      if (cre_hit)                st_mid = cre_defer ? ST_DEFER : ST_READY;
      else if (lau_hit || wak_hit) st_mid = ST_READY;
      else if (rel_hit)           st_mid = rel_state;
    end

    assign ready_mid[g] = (st_mid == ST_READY);

    // selection overlays the scheduler grant
    always_comb begin
      gnt_hit = gnt_en && (gnt_slot == SLOT_W'(g));
      st_nxt  = gnt_hit ? ST_RUN : st_mid;
      st_en   = cre_hit | lau_hit | rel_hit | wak_hit | gnt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_FREE;
        id_r  <= '0;
        tag_r <= '0;
      end else begin
        if (st_en)   st_r <= st_nxt;
        if (cre_hit) id_r <= cre_id;
        if (rel_hit && (rel_state == ST_BLOCK)) tag_r <= rel_tag;
      end
    end

    assign st_vec[g] = st_r;
    assign id_vec[g] = id_r;
  end

endmodule

// File: rtl/csched_rr_pick.sv
module csched_rr_pick #(
  parameter int N      = 8,
  parameter int SLOT_W = $clog2(N)
) (
  input  logic [N-1:0]      req,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              gnt_valid,
  output logic [SLOT_W-1:0] gnt_slot
);

  // scan from farthest to nearest so the nearest requester after last_slot wins
  always_comb begin
    gnt_valid = 1'b0;
    gnt_slot  = '0;
    for (int k = N; k >= 1; k--) begin
      int j;
      j = int'(last_slot) + k;
      if (j >= N) j = j - N;
      if (req[j]) begin
        gnt_valid = 1'b1;
        gnt_slot  = SLOT_W'(j);
      end
    end
  end

endmodule

// File: rtl/csched_done_mon.sv
module csched_done_mon #(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0][2:0] st_vec,
  output logic            all_done
);

  logic [N-1:0] used;
  logic [N-1:0] fin;
  logic         cond;
  logic         cond_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign used[g] = (st_vec[g] != 3'd0);
    assign fin[g]  = (st_vec[g] == 3'd0) || (st_vec[g] == 3'd5);
  end

  assign cond = (|used) && (&fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign all_done = cond && !cond_q;

endmodule

// File: rtl/coop_job_sched.sv
module coop_job_sched
  import csched_pkg::*;
#(
  parameter int NUM_JOBS = 8,
  parameter int ID_W     = 16,
  parameter int TAG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_job_id,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cmd_evt_done,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  output logic             run_valid,
  output logic [ID_W-1:0]  run_job_id,
  output logic             cmd_err,
  output logic             all_done
);

  localparam int SLOT_W = $clog2(NUM_JOBS);

  // asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n_i = rsync[1];

  sched_op_e op;
  logic      is_rel_op, blk_hit, rel_en, sel_en, gnt_en;
  logic      cre_en, lau_en, cre_err, lau_err;
  job_st_e   rel_state;

  logic                        run_q, run_d;
  logic [SLOT_W-1:0]           cur_q, cur_d;
  logic [SLOT_W-1:0]           last_q, last_d;
  logic                        err_q, err_d;
  logic [NUM_JOBS-1:0]         ready_mid;
  logic [NUM_JOBS-1:0][2:0]    st_vec;
  logic [NUM_JOBS-1:0][ID_W-1:0] id_vec;
  logic                        pick_valid;
  logic [SLOT_W-1:0]           pick_slot;

  always_comb begin
    op        = sched_op_e'(cmd_op);
    cre_en    = cmd_valid && ((op == OP_CREATE) || (op == OP_CREATE_DEF));
    lau_en    = cmd_valid && (op == OP_LAUNCH);
    is_rel_op = cmd_valid && ((op == OP_YIELD) || (op == OP_RETRY) ||
                              (op == OP_BLOCK) || (op == OP_END));
    blk_hit   = (op == OP_BLOCK) &&
                (cmd_evt_done || (wake_valid && (wake_tag == cmd_tag)));
    rel_en    = is_rel_op && run_q && !blk_hit;
    unique case (op)
      OP_BLOCK: rel_state = ST_BLOCK;
      OP_END:   rel_state = ST_DONE;
      default:  rel_state = ST_READY;
    endcase
    sel_en    = rel_en || !run_q;
    gnt_en    = sel_en && pick_valid;
  end

  csched_table #(
    .N(NUM_JOBS), .ID_W(ID_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cre_en    (cre_en),
    .cre_defer (op == OP_CREATE_DEF),
    .cre_id    (cmd_job_id),
    .lau_en    (lau_en),
    .lau_id    (cmd_job_id),
    .rel_en    (rel_en),
    .rel_slot  (cur_q),
    .rel_state (rel_state),
    .rel_tag   (cmd_tag),
    .wake_en   (wake_valid),
    .wake_tag  (wake_tag),
    .gnt_en    (gnt_en),
    .gnt_slot  (pick_slot),
    .ready_mid (ready_mid),
    .st_vec    (st_vec),
    .id_vec    (id_vec),
    .cre_err   (cre_err),
    .lau_err   (lau_err)
  );

  csched_rr_pick #(.N(NUM_JOBS), .SLOT_W(SLOT_W)) u_pick (
    .req       (ready_mid),
    .last_slot (last_q),
    .gnt_valid (pick_valid),
    .gnt_slot  (pick_slot)
  );

  csched_done_mon #(.N(NUM_JOBS)) u_done (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .st_vec   (st_vec),
    .all_done (all_done)
  );

  always_comb begin
    run_d  = sel_en ? pick_valid : run_q;
    cur_d  = gnt_en ? pick_slot : cur_q;
    last_d = gnt_en ? pick_slot : last_q;
    err_d  = cre_err || lau_err || (is_rel_op && !run_q);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q  <= 1'b0;
      cur_q  <= '0;
      last_q <= SLOT_W'(NUM_JOBS - 1);
      err_q  <= 1'b0;
    end else begin
      if (sel_en) run_q  <= run_d;
      if (gnt_en) cur_q  <= cur_d;
      if (gnt_en) last_q <= last_d;
      err_q <= err_d;
    end
  end

  assign run_valid  = run_q;
  assign run_job_id = run_q ? id_vec[cur_q] : '0;
  assign cmd_err    = err_q;

endmodule

// File: rtl/coop_job_sched_chk.sv
module coop_job_sched_chk #(
  parameter int N      = 8,
  parameter int SLOT_W = 3,
  parameter int ID_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              cmd_evt_done,
  input logic              run_valid,
  input logic [ID_W-1:0]   run_job_id,
  input logic              cmd_err,
  input logic              all_done,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [N-1:0][2:0] st_vec
);

  logic [N-1:0] run_bits;
  for (genvar g = 0; g < N; g++) begin : g_rb
    assign run_bits[g] = (st_vec[g] == 3'd3);
  end

  assert_single_runner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_bits) == (run_valid ? 1 : 0));

  assert_runner_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> (st_vec[cur_slot] == 3'd3));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> !all_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !run_valid);

  assert_evt_done_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && cmd_valid && (cmd_op == 3'd6) && cmd_evt_done)
      |=> (run_valid && $stable(run_job_id)));

  assert_idle_release_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_valid && cmd_valid && (cmd_op >= 3'd4)) |=> cmd_err);

endmodule

bind coop_job_sched coop_job_sched_chk #(
  .N(NUM_JOBS), .SLOT_W(SLOT_W), .ID_W(ID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_evt_done (cmd_evt_done),
  .run_valid    (run_valid),
  .run_job_id   (run_job_id),
  .cmd_err      (cmd_err),
  .all_done     (all_done),
  .cur_slot     (cur_q),
  .st_vec       (st_vec)
);

// File: tb/coop_job_sched_tb.sv
module coop_job_sched_tb;

  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_job_id;
  logic [7:0]  cmd_tag;
  logic        cmd_evt_done;
  logic        wake_valid;
  logic [7:0]  wake_tag;
  logic        run_valid;
  logic [15:0] run_job_id;
  logic        cmd_err;
  logic        all_done;

  int total;
  int bad;

  // bench model: 0 free,1 deferred,2 ready,3 running,4 parked,5 finished
  int          m_st  [N];
  logic [15:0] m_id  [N];
  logic [7:0]  m_tag [N];
  bit          m_run;
  int          m_cur;
  int          m_last;
  bit          m_cond;
  bit          e_err;
  bit          e_done;
  bit          saw_done;

  coop_job_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_job_id(cmd_job_id), .cmd_tag(cmd_tag), .cmd_evt_done(cmd_evt_done),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .run_valid(run_valid),
    .run_job_id(run_job_id), .cmd_err(cmd_err), .all_done(all_done)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(string rq, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  task automatic model_step(int op, logic [15:0] id, logic [7:0] tag, bit evt,
                            bit wv, logic [7:0] wt);
    int  ns [N];
    bit  rel;
    bit  found;
    int  fs;
    int  pick;
    bit  cond;
    bit  any_used;
    bit  all_fin;
    rel   = 0;
    e_err = 0;
    for (int i = 0; i < N; i++) ns[i] = m_st[i];
    if (op == 1 || op == 2) begin
      found = 0;
      for (int i = 0; i < N; i++) if (m_st[i] != 0 && m_id[i] == id) found = 1;
      if (!found) begin
        fs = -1;
        for (int i = N - 1; i >= 0; i--) if (m_st[i] == 0) fs = i;
        if (fs < 0) e_err = 1;
        else begin
          ns[fs]   = (op == 2) ? 1 : 2;
          m_id[fs] = id;
        end
      end
    end else if (op == 3) begin
      found = 0;
      for (int i = 0; i < N; i++)
        if (m_st[i] == 1 && m_id[i] == id) begin ns[i] = 2; found = 1; end
      if (!found) e_err = 1;
    end else if (op >= 4) begin
      if (!m_run) e_err = 1;
      else if (op == 6 && (evt || (wv && wt == tag))) rel = 0;
      else begin
        rel = 1;
        ns[m_cur] = (op == 7) ? 5 : (op == 6) ? 4 : 2;
        if (op == 6) m_tag[m_cur] = tag;
      end
    end
    if (wv)
      for (int i = 0; i < N; i++) if (m_st[i] == 4 && m_tag[i] == wt) ns[i] = 2;
    if (rel || !m_run) begin
      pick = -1;
      for (int k = N; k >= 1; k--) if (ns[(m_last + k) % N] == 2) pick = (m_last + k) % N;
      if (pick >= 0) begin
        ns[pick] = 3; m_run = 1; m_cur = pick; m_last = pick;
      end else m_run = 0;
    end
    any_used = 0; all_fin = 1;
    for (int i = 0; i < N; i++) begin
      if (ns[i] != 0) any_used = 1;
      if (ns[i] != 0 && ns[i] != 5) all_fin = 0;
    end
    cond   = any_used && all_fin;
    e_done = cond && !m_cond;
    m_cond = cond;
    for (int i = 0; i < N; i++) m_st[i] = ns[i];
  endtask

  task automatic step(string rq, int op, logic [15:0] id, logic [7:0] tag,
                      bit evt, bit wv, logic [7:0] wt);
    cmd_valid    = (op != 0);
    cmd_op       = 3'(op);
    cmd_job_id   = id;
    cmd_tag      = tag;
    cmd_evt_done = evt;
    wake_valid   = wv;
    wake_tag     = wt;
    model_step(op, id, tag, evt, wv, wt);
    @(posedge clk);
    @(negedge clk);
    cmd_valid  = 1'b0;
    wake_valid = 1'b0;
    chk(rq, "run_valid", 32'(run_valid), 32'(m_run));
    chk(rq, "run_job_id", 32'(run_job_id), m_run ? 32'(m_id[m_cur]) : 32'd0);
    chk(rq, "cmd_err", 32'(cmd_err), 32'(e_err));
    chk(rq, "all_done", 32'(all_done), 32'(e_done));
    if (all_done) saw_done = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev;
    total = 0; bad = 0; saw_done = 0;
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_id[i] = '0; m_tag[i] = '0; end
    m_run = 0; m_cur = 0; m_last = N - 1; m_cond = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_job_id = '0; cmd_tag = '0;
    cmd_evt_done = 1'b0; wake_valid = 1'b0; wake_tag = '0;
    repeat (3) @(negedge clk);
    chk("R1", "run_valid in reset", 32'(run_valid), 0);
    chk("R1", "cmd_err in reset", 32'(cmd_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "run_valid", 32'(run_valid), 0);
    chk("R1", "run_job_id", 32'(run_job_id), 0);
    chk("R1", "all_done", 32'(all_done), 0);

    // R2: immediate jobs
    for (int i = 0; i < 4; i++) step("R2", 1, 16'h0010 + 16'(i), 0, 0, 0, 0);
    // R3: deferred jobs stay out of the rotation
    step("R3", 2, 16'h0020, 0, 0, 0, 0);
    step("R3", 2, 16'h0021, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R4", 4, 0, 0, 0, 0, 0);
    step("R3", 3, 16'h0020, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R3", 4, 0, 0, 0, 0, 0);
    // R8: bad launches
    step("R8", 3, 16'h0020, 0, 0, 0, 0);
    step("R8", 3, 16'h0077, 0, 0, 0, 0);
    // R5: retry rotates like yield
    for (int i = 0; i < 3; i++) step("R5", 5, 0, 0, 0, 0, 0);
    // R6: park and wake by tag
    step("R6", 6, 0, 8'h05, 0, 0, 0);
    step("R6", 6, 0, 8'h06, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 8'h09);
    for (int i = 0; i < 4; i++) step("R6", 4, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 8'h05);
    for (int i = 0; i < 4; i++) step("R6", 4, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 8'h06);
    for (int i = 0; i < 3; i++) step("R6", 5, 0, 0, 0, 0, 0);
    // R7: already complete, and same-cycle wake
    prev = int'(run_job_id);
    step("R7", 6, 0, 8'h03, 1, 0, 0);
    chk("R7", "id after evt_done block", 32'(run_job_id), 32'(prev));
    step("R7", 6, 0, 8'h03, 0, 1, 8'h03);
    chk("R7", "id after same-cycle wake", 32'(run_job_id), 32'(prev));
    // R12 / R11: duplicates and full table
    step("R12", 1, 16'h0011, 0, 0, 0, 0);
    step("R11", 1, 16'h0030, 0, 0, 0, 0);
    step("R11", 1, 16'h0031, 0, 0, 0, 0);
    step("R11", 1, 16'h0032, 0, 0, 0, 0);
    step("R12", 1, 16'h0010, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R11", 4, 0, 0, 0, 0, 0);
    // R10: park everything, then release
    for (int i = 0; i < 10; i++) if (m_run) step("R10", 6, 0, 8'h40, 0, 0, 0);
    chk("R10", "idle after all parked", 32'(run_valid), 0);
    step("R8", 4, 0, 0, 0, 0, 0);
    step("R8", 7, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 8'h40);
    step("R3", 3, 16'h0021, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R4", 4, 0, 0, 0, 0, 0);
    // R9: finish all jobs
    for (int i = 0; i < 20; i++) if (m_run) step("R9", 7, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 0, 1, 8'h40);
    chk("R9", "all_done seen", 32'(saw_done), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule